// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block collects interrupt events for one event group (for example transmit completions, receive completions or miscellaneous notifications) into a 32-bit cause register and raises a single interrupt line while any pending cause is not masked. Hardware sources deliver one-cycle pulses on a per-bit event input. Each pulse sets the matching cause bit, and the bit stays set until software clears it.

Software reaches the bank through a plain word-addressed read/write port. The mask is never written directly. One write port sets mask bits and another clears them, so two agents can change different sources without a read-modify-write race. The current mask can be read back. A per-bit clear-mode register picks, for each cause bit, whether a read of the cause register clears it or whether writing a 1 to it clears it. A driver can therefore run the whole group in either style, or mix the two.

Top module: `icr_bank`

## Requirements
- R1: After reset the mask value reads 0xFFFFFFFF, the clear-mode register reads 0, the cause register reads 0 and `irq_o` is 0.
- R2: An event pulse on `ev_pulse_i[n]` sets cause bit n whether or not bit n is masked. A later read of the cause register (word address 0) returns the bit.
- R3: For cause bits whose clear-mode bit is 0, writing 1 to that bit at word address 0 clears it. Zero bits in the write leave the cause unchanged. A read does not clear these bits. Writes at address 0 have no effect on bits whose clear-mode bit is 1.
- R4: A read at word address 0 returns the cause value from before the read. It clears exactly those pending bits whose clear-mode bit is 1.
- R5: Writing at word address 1 sets every mask bit where the write data is 1 and leaves the other mask bits unchanged.
- R6: Writing at word address 2 clears every mask bit where the write data is 1 and leaves the other mask bits unchanged.
- R7: A read at word address 3 returns the mask without changing it. Reads at addresses 1 and 2 return 0.
- R8: Word address 4 holds the clear-mode register. It is readable and writable, and 1 in a bit selects clear-on-read for that bit. Addresses 5 to 7 read 0 and ignore writes.
- R9: If an event pulse and a clear (a write-1 or a clear-on-read) hit the same cause bit in the same cycle, the bit stays set.
- R10: `irq_o` is a register equal to the OR of cause bits whose mask bit is 0. It follows a change of cause or mask one clock later.
- R11: `reg_rdata_o` is registered. It shows the addressed value in the cycle after `reg_rd_i` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_pulse_i | input | 32 | Per-bit hardware event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, high while an unmasked cause is pending |

## Verification
A lost or stuck cause bit shows up at the next read of address 0, one cycle after the read strobe. It also shows on `irq_o` one cycle after the cause changes, provided that bit is unmasked. A wrong mask bit appears directly in the address-3 readback, and it also holds `irq_o` high or low one cycle after the pending cause would have changed it. A clear-mode error becomes visible on the second of two back-to-back cause reads: a bit that should have survived has vanished, or a bit that should have gone is still there. The set-versus-clear race shows up on the read that follows the collision.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  // Word offsets inside the register group
  typedef enum logic [ADDR_W-1:0] {
    OFS_CAUSE = 3'd0,
    OFS_MSET  = 3'd1,
    OFS_MCLR  = 3'd2,
    OFS_MVAL  = 3'd3,
    OFS_CMODE = 3'd4
  } icr_ofs_e;

  typedef struct packed {
    logic cause_wr;
    logic cause_rd;
    logic mset_wr;
    logic mclr_wr;
    logic cmode_wr;
  } icr_strb_t;
endpackage

// File: rtl/icr_rst_sync.sv
module icr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/icr_addr_dec.sv
module icr_addr_dec
  import icr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  output icr_strb_t     strb_o
);
  always_comb begin
    strb_o          = '0;
    strb_o.cause_wr = wr_i && (addr_i == OFS_CAUSE);
    strb_o.cause_rd = rd_i && (addr_i == OFS_CAUSE);
    strb_o.mset_wr  = wr_i && (addr_i == OFS_MSET);
    strb_o.mclr_wr  = wr_i && (addr_i == OFS_MCLR);
    strb_o.cmode_wr = wr_i && (addr_i == OFS_CMODE);
  end
endmodule

// File: rtl/icr_mask_reg.sv
module icr_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_en = set_en_i | clr_en_i;
    mask_d  = mask_q;
    if (set_en_i) mask_d = mask_d | bits_i;
    if (clr_en_i) mask_d = mask_d & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/icr_cause_reg.sv
module icr_cause_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         w1c_en_i,
  input  logic         rd_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cor_sel_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;
  logic [W-1:0] cause_d;
  logic [W-1:0] clr_vec;
  logic [W-1:0] bit_en;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      clr_vec[b] = (w1c_en_i & wdata_i[b] & ~cor_sel_i[b])
                 | (rd_en_i  & cor_sel_i[b]);
      // a set in the same cycle as a clear wins
      cause_d[b] = ev_i[b] | (cause_q[b] & ~clr_vec[b]);
      bit_en[b]  = ev_i[b] | clr_vec[b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cause_q[b] <= 1'b0;
      else if (bit_en[b]) cause_q[b] <= cause_d[b];
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/icr_bank.sv
module icr_bank
  import icr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ev_pulse_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic          rst_n_sync;
  icr_strb_t     strb;
  logic [DW-1:0] cause_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] cmode_q;
  logic [DW-1:0] cmode_d;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;
  logic          irq_d;
  logic          irq_q;

  icr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_sync)
  );

  icr_addr_dec #(.AW(AW)) u_dec (
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .strb_o (strb)
  );

  icr_mask_reg #(.W(DW)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .set_en_i (strb.mset_wr),
    .clr_en_i (strb.mclr_wr),
    .bits_i   (reg_wdata_i),
    .mask_o   (mask_q)
  );

  icr_cause_reg #(.W(DW)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .ev_i      (ev_pulse_i),
    .w1c_en_i  (strb.cause_wr),
    .rd_en_i   (strb.cause_rd),
    .wdata_i   (reg_wdata_i),
    .cor_sel_i (cmode_q),
    .cause_o   (cause_q)
  );

  // clear-mode register: 1 = clear on read, 0 = write 1 to clear
  always_comb cmode_d = reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync)        cmode_q <= '0;
    else if (strb.cmode_wr) cmode_q <= cmode_d;
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_CAUSE: rd_mux = cause_q;
      OFS_MVAL:  rd_mux = mask_q;
      OFS_CMODE: rd_mux = cmode_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync)   rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  always_comb irq_d = |(cause_q & ~mask_q);

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/icr_bank_chk.sv
module icr_bank_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_n_sync,
  input logic [DW-1:0] ev_pulse_i,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          irq_o,
  input logic [DW-1:0] cause_q,
  input logic [DW-1:0] mask_q
);
  AST_EVENT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (|ev_pulse_i) |=> ((cause_q & $past(ev_pulse_i)) == $past(ev_pulse_i))); // R9

  AST_MASK_SET_PORT: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (reg_wr_i && reg_addr_i == 3'd1) |=> ((mask_q & $past(reg_wdata_i)) == $past(reg_wdata_i))); // R5

  AST_MASK_CLR_PORT: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (reg_wr_i && reg_addr_i == 3'd2) |=> ((mask_q & $past(reg_wdata_i)) == '0)); // R6

  AST_MASK_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (reg_rd_i && !reg_wr_i) |=> $stable(mask_q)); // R7

  AST_CAUSE_READ_VALUE: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (reg_rd_i && reg_addr_i == 3'd0) |=> (reg_rdata_o == $past(cause_q))); // R4

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    1'b1 |=> (irq_o == |($past(cause_q) & ~$past(mask_q)))); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R11
endmodule

bind icr_bank icr_bank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_n_sync  (rst_n_sync),
  .ev_pulse_i  (ev_pulse_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .cause_q     (cause_q),
  .mask_q      (mask_q)
);

// File: tb/icr_bank_tb.sv
module icr_bank_tb;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int NV = 29;
  localparam int VW = 2 + AW + 3 * DW;

  // op: 0 idle, 1 write, 2 read (rdata checked after the cycle)
  function automatic logic [VW-1:0] v(input logic [1:0] op, input logic [2:0] a,
                                      input logic [31:0] wd, input logic [31:0] ev,
                                      input logic [31:0] ex);
    return {op, a, wd, ev, ex};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    v(2, 3, 0, 0, 32'hFFFF_FFFF),                // 0  R1 R7 mask after reset
    v(2, 4, 0, 0, 32'h0),                        // 1  R1 clear-mode
    v(2, 0, 0, 0, 32'h0),                        // 2  R1 cause
    v(0, 0, 0, 32'h0000_00A5, 0),                // 3  R2 events while masked
    v(2, 0, 0, 0, 32'h0000_00A5),                // 4  R2
    v(2, 0, 0, 0, 32'h0000_00A5),                // 5  R3 read does not clear
    v(1, 0, 32'h0000_0005, 0, 0),                // 6  R3 write-1 clear
    v(2, 0, 0, 0, 32'h0000_00A0),                // 7  R3
    v(1, 2, 32'h0000_00F0, 0, 0),                // 8  R6
    v(2, 3, 0, 0, 32'hFFFF_FF0F),                // 9  R6
    v(1, 1, 32'h0000_0030, 0, 0),                // 10 R5
    v(2, 3, 0, 0, 32'hFFFF_FF3F),                // 11 R5
    v(2, 1, 0, 0, 32'h0),                        // 12 R7 set port reads 0
    v(1, 4, 32'h0000_FF00, 0, 0),                // 13 R8
    v(2, 4, 0, 0, 32'h0000_FF00),                // 14 R8
    v(0, 0, 0, 32'h0000_1200, 0),                // 15 R2
    v(1, 0, 32'h0000_1280, 0, 0),                // 16 R3 COR bits ignore write
    v(2, 0, 0, 0, 32'h0000_1220),                // 17 R4 returns pre-clear
    v(2, 0, 0, 0, 32'h0000_0020),                // 18 R4 only COR bits cleared
    v(1, 0, 32'h0000_0020, 32'h0000_0020, 0),    // 19 R9 set beats W1C
    v(2, 0, 0, 0, 32'h0000_0020),                // 20 R9
    v(2, 0, 0, 32'h0000_0200, 32'h0000_0020),    // 21 R9 set during COR read
    v(2, 0, 0, 0, 32'h0000_0220),                // 22 R9
    v(1, 0, 32'h0000_0020, 0, 0),                // 23 R3
    v(2, 0, 0, 0, 32'h0),                        // 24 R3
    v(1, 5, 32'hFFFF_FFFF, 0, 0),                // 25 R8 unused write
    v(2, 5, 0, 0, 32'h0),                        // 26 R8
    v(2, 3, 0, 0, 32'hFFFF_FF3F),                // 27 R8 mask untouched
    v(2, 2, 0, 0, 32'h0)                         // 28 R7 clear port reads 0
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [DW-1:0] ev_pulse_i;
  logic          reg_wr_i;
  logic          reg_rd_i;
  logic [AW-1:0] reg_addr_i;
  logic [DW-1:0] reg_wdata_i;
  logic [DW-1:0] reg_rdata_o;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  icr_bank u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_pulse_i  (ev_pulse_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = 0; reg_wdata_i = 0; ev_pulse_i = 0;
  endtask

  // one access cycle: drive at negedge, returns at the following negedge
  task automatic acc(input logic wr, input logic rd, input logic [2:0] a,
                     input logic [31:0] wd, input logic [31:0] ev);
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = wd; ev_pulse_i = ev;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    do_reset();
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [2:0]  a;
      logic [31:0] wd, ev, ex;
      {op, a, wd, ev, ex} = VEC[i];
      acc(op == 2'd1, op == 2'd2, a, wd, ev);
      if (op == 2'd2) chk($sformatf("vector %0d (R1-style tag in table comment)", i), reg_rdata_o, ex);
    end

    // R10: mask is FFFFFF3F, bits 6 and 7 unmasked, cause empty
    acc(0, 0, 0, 0, 32'h1);               // bit0 masked
    @(negedge clk_i);
    chk("R10 masked cause no irq", {31'b0, irq_o}, 32'h0);
    acc(0, 0, 0, 0, 32'h40);              // bit6 unmasked, cause set this edge
    chk("R10 irq lags cause", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R10 irq raised", {31'b0, irq_o}, 32'h1);
    acc(1, 0, 1, 32'h40, 0);              // mask bit6
    chk("R10 irq lags mask", {31'b0, irq_o}, 32'h1);
    @(negedge clk_i);
    chk("R10 irq dropped after mask set", {31'b0, irq_o}, 32'h0);
    acc(1, 0, 2, 32'h1, 0);               // unmask bit0 (pending)
    @(negedge clk_i);
    chk("R10 R6 irq from pending masked bit", {31'b0, irq_o}, 32'h1);
    acc(1, 0, 0, 32'h41, 0);              // W1C both
    @(negedge clk_i);
    chk("R10 irq gone after clear", {31'b0, irq_o}, 32'h0);

    // R11: rdata holds without a read strobe
    acc(0, 1, 3, 0, 0);
    chk("R11 read mask", reg_rdata_o, 32'hFFFF_FF7E);
    acc(1, 1, 0, 32'h0, 0);
    acc(0, 0, 4, 0, 0);
    @(negedge clk_i);
    chk("R11 rdata held", reg_rdata_o, 32'h0);
    acc(0, 0, 4, 0, 0);
    chk("R11 rdata held without strobe", reg_rdata_o, 32'h0);

    // R1: reset in the middle of activity
    acc(0, 0, 0, 0, 32'hFFFF_0000);
    acc(1, 0, 2, 32'hFFFF_FFFF, 0);
    acc(1, 0, 4, 32'h1234_5678, 0);
    do_reset();
    chk("R1 irq after second reset", {31'b0, irq_o}, 32'h0);
    acc(0, 1, 3, 0, 0);
    chk("R1 mask after second reset", reg_rdata_o, 32'hFFFF_FFFF);
    acc(0, 1, 4, 0, 0);
    chk("R1 clear-mode after second reset", reg_rdata_o, 32'h0);
    acc(0, 1, 0, 0, 0);
    chk("R1 cause after second reset", reg_rdata_o, 32'h0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule